// File: doc/BRIEF.md
# Sorted Candidate List Expand-and-Merge Stage

This block is a single pipeline stage of a generator that builds, bit by bit, a list of candidate symbols ordered by increasing cost. It accepts an ordered input list of (cost, partial symbol) couples. The couples arrive one per clock on consecutive cycles. The stage also takes one channel sample, given as a magnitude and a sign. From the sign it forms a hard-decision bit: 0 when the sample is negative, 1 otherwise.

Each incoming couple is split into two candidates, and the new bit is appended as the least significant symbol bit. The first candidate carries the hard-decision bit and keeps its cost. The second carries the inverted bit, and its cost is raised by the sample magnitude with saturation. Each candidate stream is already sorted, and each is held in its own small FIFO. A minimum-select merge compares the two FIFO heads every cycle and pops the cheaper one. It registers that couple onto the output. The output list is cut off at `S_OUT = min(2^(SW+1), NM)` couples.

Before each new list, a synchronous clear returns the stage to empty. A chain of these stages, each with a wider symbol, forms the full generator.

Top module: `sorted_expand_merge`

## Requirements
- R1: For input couple (L, X), the zero-cost candidate is (L, {X, d}), with the new bit as the output symbol LSB. Here d = 0 when `y_neg` is 1 and d = 1 when `y_neg` is 0.
- R2: For input couple (L, X), the penalised candidate is (L + `y_mag`, {X, ~d}).
- R3: The penalised cost saturates at 2^NB - 1 and never wraps.
- R4: The output costs within one list never decrease. On each emission, the cheaper of the two FIFO heads is taken.
- R5: When the two heads have equal cost, the zero-cost-stream entry is emitted first.
- R6: Exactly `S_OUT` couples are emitted per list. `out_valid` is high only on cycles that carry an emitted couple, and it stays low after the list until the next clear.
- R7: The input list has `S_IN = min(2^SW, NM)` couples on consecutive cycles. The first output appears in the cycle after the first input is sampled. Output then continues one couple per cycle.
- R8: Once the whole input list has been taken and the zero-cost FIFO is empty, the remaining penalised candidates are emitted in their stored order.
- R9: The penalised FIFO holds floor(S_OUT/2) entries and accepts only the first floor(S_OUT/2) candidates. The zero-cost FIFO holds floor((S_OUT-1)/2)+1 entries. Neither FIFO ever overflows or underflows.
- R10: When `clr` is sampled high, both FIFOs are emptied and both counters are reset. Inputs on that cycle are ignored, and `out_valid` is low in the following cycle.
- R11: After reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear before a new list |
| in_valid | input | 1 | Input couple present this cycle |
| in_cost | input | NB | Cost of the input couple |
| in_sym | input | SW | Partial symbol of the input couple |
| y_mag | input | NB | Magnitude of the channel sample |
| y_neg | input | 1 | Sign of the channel sample, 1 = negative |
| out_valid | output | 1 | Output couple emitted this cycle |
| out_cost | output | NB | Cost of the emitted couple |
| out_sym | output | SW+1 | Extended symbol of the emitted couple |

## Verification
The merge is tried with several input patterns. A mixed list shows that a small penalty interleaves the two streams. A zero magnitude makes every pair tie and exposes the tie order. A very large magnitude empties the zero-cost stream first, which exercises the drain rule and saturation. Widely spaced costs make the selection alternate between the streams, which pushes the zero-cost FIFO to its deepest use. Both sample signs are used, so the appended bit and its inverse can be told apart. A clear in mid-list shows that no stale entries leak into the next list.

// File: rtl/sem_pkg.sv
package sem_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_ZERO = 2'd1,
        SRC_PEN  = 2'd2
    } src_e;
endpackage

// File: rtl/sem_expand.sv
module sem_expand #(
    parameter int NB = 8,
    parameter int SW = 3
) (
    input  logic [NB-1:0] in_cost,
    input  logic [SW-1:0] in_sym,
    input  logic [NB-1:0] y_mag,
    input  logic          y_neg,
    output logic [NB-1:0] zc_cost,
    output logic [SW:0]   zc_sym,
    output logic [NB-1:0] pc_cost,
    output logic [SW:0]   pc_sym
);
    logic          hard_bit;
    logic [NB:0]   wide_sum;

    always_comb begin
        hard_bit = ~y_neg;
        wide_sum = {1'b0, in_cost} + {1'b0, y_mag};
        zc_cost  = in_cost;
        zc_sym   = {in_sym, hard_bit};
        pc_cost  = wide_sum[NB] ? {NB{1'b1}} : wide_sum[NB-1:0];
        pc_sym   = {in_sym, ~hard_bit};
    end
endmodule

// File: rtl/sem_fifo.sv
module sem_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.mem[st_q.wp] = wdata;
            st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + AW'(1);
        end
        if (rd) begin
            st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + AW'(1);
        end
        st_d.cnt = st_q.cnt + CW'(wr) - CW'(rd);
        if (clr) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

    // R9: a write into a full buffer must be paired with a read
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full) |-> rd);
    // R9: never pop an empty buffer
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> !empty);
endmodule

// File: rtl/sem_select.sv
module sem_select #(
    parameter int NB = 8,
    parameter int OW = 4
) (
    input  logic [NB-1:0]  h0_cost,
    input  logic [OW-1:0]  h0_sym,
    input  logic           h0_v,
    input  logic [NB-1:0]  h1_cost,
    input  logic [OW-1:0]  h1_sym,
    input  logic           h1_v,
    input  logic           go,
    input  logic           drain_ok,
    output sem_pkg::src_e  src,
    output logic [NB-1:0]  sel_cost,
    output logic [OW-1:0]  sel_sym
);
    import sem_pkg::*;

    always_comb begin
        src = SRC_NONE;
        if (go) begin
            if (h0_v && h1_v)       src = (h1_cost < h0_cost) ? SRC_PEN : SRC_ZERO;
            else if (h0_v)          src = SRC_ZERO;
            else if (h1_v && drain_ok) src = SRC_PEN;
        end
        sel_cost = (src == SRC_PEN) ? h1_cost : h0_cost;
        sel_sym  = (src == SRC_PEN) ? h1_sym  : h0_sym;
    end
endmodule

// File: rtl/sorted_expand_merge.sv
module sorted_expand_merge #(
    parameter int NB = 8,
    parameter int SW = 3,
    parameter int NM = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          in_valid,
    input  logic [NB-1:0] in_cost,
    input  logic [SW-1:0] in_sym,
    input  logic [NB-1:0] y_mag,
    input  logic          y_neg,
    output logic          out_valid,
    output logic [NB-1:0] out_cost,
    output logic [SW:0]   out_sym
);
    import sem_pkg::*;

    localparam int OW    = SW + 1;
    localparam int S_IN  = ((2 ** SW) < NM) ? (2 ** SW) : NM;
    localparam int S_OUT = ((2 ** OW) < NM) ? (2 ** OW) : NM;
    localparam int PEN_D = S_OUT / 2;
    localparam int ZER_D = (S_OUT - 1) / 2 + 1;
    localparam int ICW   = $clog2(S_IN + 1);
    localparam int OCW   = $clog2(S_OUT + 1);
    localparam int EW    = NB + OW;

    typedef struct packed {
        logic [ICW-1:0] in_cnt;
        logic [OCW-1:0] out_cnt;
        logic           ov;
        logic [NB-1:0]  oc;
        logic [OW-1:0]  os;
    } stage_st_t;

    stage_st_t st_d, st_q;

    logic [NB-1:0] zc_cost, pc_cost, h0_cost, h1_cost, sel_cost;
    logic [OW-1:0] zc_sym, pc_sym, h0_sym, h1_sym, sel_sym;
    logic [EW-1:0] h0_raw, h1_raw;
    logic          wr0, wr1, rd0, rd1, e0, e1, f0, f1, go, drain_ok;
    src_e          src;

    sem_expand #(.NB(NB), .SW(SW)) u_expand (
        .in_cost(in_cost), .in_sym(in_sym), .y_mag(y_mag), .y_neg(y_neg),
        .zc_cost(zc_cost), .zc_sym(zc_sym), .pc_cost(pc_cost), .pc_sym(pc_sym)
    );

    assign wr0      = in_valid && !clr && (st_q.in_cnt < ICW'(S_IN));
    assign wr1      = wr0 && (st_q.in_cnt < ICW'(PEN_D));
    assign go       = !clr && (st_q.out_cnt < OCW'(S_OUT));
    assign drain_ok = (st_q.in_cnt == ICW'(S_IN));

    sem_fifo #(.W(EW), .DEPTH(ZER_D)) u_fifo_zero (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .wr(wr0), .wdata({zc_cost, zc_sym}), .rd(rd0),
        .rdata(h0_raw), .empty(e0), .full(f0)
    );

    sem_fifo #(.W(EW), .DEPTH(PEN_D)) u_fifo_pen (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .wr(wr1), .wdata({pc_cost, pc_sym}), .rd(rd1),
        .rdata(h1_raw), .empty(e1), .full(f1)
    );

    assign {h0_cost, h0_sym} = h0_raw;
    assign {h1_cost, h1_sym} = h1_raw;

    sem_select #(.NB(NB), .OW(OW)) u_select (
        .h0_cost(h0_cost), .h0_sym(h0_sym), .h0_v(!e0),
        .h1_cost(h1_cost), .h1_sym(h1_sym), .h1_v(!e1),
        .go(go), .drain_ok(drain_ok),
        .src(src), .sel_cost(sel_cost), .sel_sym(sel_sym)
    );

    assign rd0 = (src == SRC_ZERO);
    assign rd1 = (src == SRC_PEN);

    always_comb begin
        st_d        = st_q;
        st_d.in_cnt = st_q.in_cnt + ICW'(wr0);
        st_d.ov     = (src != SRC_NONE);
        if (src != SRC_NONE) begin
            st_d.out_cnt = st_q.out_cnt + OCW'(1);
            st_d.oc      = sel_cost;
            st_d.os      = sel_sym;
        end
        if (clr) begin
            st_d.in_cnt  = '0;
            st_d.out_cnt = '0;
            st_d.ov      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ov;
    assign out_cost  = st_q.oc;
    assign out_sym   = st_q.os;

    // R4: consecutive emitted costs never decrease
    p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_cost >= $past(out_cost)));
    // R5: equal heads resolve to the zero-cost stream
    p_tie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !e0 && !e1 && (h0_cost == h1_cost)) |-> rd0);
    // R6: the emitted count never passes the list length
    p_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.out_cnt <= OCW'(S_OUT));
    // R7: once a list has started, inputs keep coming every cycle until it is complete
    p_contig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (st_q.in_cnt != '0) && (st_q.in_cnt < ICW'(S_IN))) |-> in_valid);
    // R10: a clear silences the output in the next cycle
    p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> !out_valid);
endmodule

// File: tb/sorted_expand_merge_tb.sv
module sorted_expand_merge_tb;
    localparam int NB    = 8;
    localparam int SW    = 3;
    localparam int NM    = 10;
    localparam int OW    = SW + 1;
    localparam int S_IN  = ((2 ** SW) < NM) ? (2 ** SW) : NM;
    localparam int S_OUT = ((2 ** OW) < NM) ? (2 ** OW) : NM;
    localparam int MAXC  = (2 ** NB) - 1;

    logic          clk = 1'b0;
    logic          rst_n, clr, in_valid, y_neg;
    logic [NB-1:0] in_cost, y_mag;
    logic [SW-1:0] in_sym;
    logic          out_valid;
    logic [NB-1:0] out_cost;
    logic [OW-1:0] out_sym;

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    sorted_expand_merge #(.NB(NB), .SW(SW), .NM(NM)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_cost(in_cost), .in_sym(in_sym), .y_mag(y_mag), .y_neg(y_neg),
        .out_valid(out_valid), .out_cost(out_cost), .out_sym(out_sym)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sat(input int v);
        return (v > MAXC) ? MAXC : v;
    endfunction

    // Behavioural reference: stable merge of the two candidate lists, first S_OUT kept.
    task automatic run_list(input int c[], input int s[], input int mag,
                            input bit neg, input string tag);
        int exp_c[$];
        int exp_s[$];
        int i0 = 0;
        int i1 = 0;
        int d  = neg ? 0 : 1;
        while (exp_c.size() < S_OUT && (i0 < S_IN || i1 < S_IN)) begin
            int a = (i0 < S_IN) ? c[i0] : 1 << 20;
            int b = (i1 < S_IN) ? sat(c[i1] + mag) : 1 << 20;
            if (a <= b) begin
                exp_c.push_back(a); exp_s.push_back((s[i0] << 1) | d); i0++;
            end else begin
                exp_c.push_back(b); exp_s.push_back((s[i1] << 1) | (1 - d)); i1++;
            end
        end
        @(negedge clk);
        clr = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        clr = 1'b0;
        chk(out_valid == 1'b0, "R10", int'(out_valid), 0);
        y_mag = NB'(mag);
        y_neg = neg;
        for (int i = 0; i < S_OUT + 4; i++) begin
            in_valid = (i < S_IN);
            in_cost  = (i < S_IN) ? NB'(c[i]) : '0;
            in_sym   = (i < S_IN) ? SW'(s[i]) : '0;
            @(negedge clk);
            if (i >= 1 && i <= S_OUT) begin
                // R7: one output per cycle starting the cycle after the first input
                chk(out_valid == 1'b1, "R7", int'(out_valid), 1);
                chk(int'(out_cost) == exp_c[i-1], {tag, " cost"}, int'(out_cost), exp_c[i-1]);
                chk(int'(out_sym) == exp_s[i-1], {tag, " symbol R1 R2"}, int'(out_sym), exp_s[i-1]);
            end else begin
                // R6: nothing emitted outside the list
                chk(out_valid == 1'b0, "R6", int'(out_valid), 0);
            end
        end
        in_valid = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int c[];
        int s[];
        rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; in_cost = '0; in_sym = '0;
        y_mag = '0; y_neg = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11", int'(out_valid), 0);

        // Mixed interleave, negative sample, one tie at cost 15 (R1 R2 R4 R5)
        c = '{0, 7, 8, 12, 15, 19, 20, 27};
        s = '{3, 7, 1, 2, 5, 6, 0, 4};
        run_list(c, s, 3, 1'b1, "R4");

        // Zero magnitude: every pair ties, zero-cost first (R5), positive sample
        c = '{1, 2, 2, 5, 9, 9, 30, 31};
        s = '{0, 1, 2, 3, 4, 5, 6, 7};
        run_list(c, s, 0, 1'b0, "R5");

        // Large penalty near the top of range: saturation (R3)
        c = '{10, 40, 80, 120, 160, 200, 240, 250};
        s = '{7, 6, 5, 4, 3, 2, 1, 0};
        run_list(c, s, 200, 1'b1, "R3");

        // Maximum penalty: zero-cost list runs out, drain of penalised entries (R8)
        c = '{0, 1, 2, 3, 4, 5, 6, 7};
        s = '{5, 2, 7, 0, 1, 6, 3, 4};
        run_list(c, s, 255, 1'b0, "R8");

        // Widely spaced costs: selection alternates, deepest zero-cost buffering (R9)
        c = '{0, 10, 20, 30, 40, 50, 60, 70};
        s = '{1, 3, 5, 7, 0, 2, 4, 6};
        run_list(c, s, 5, 1'b1, "R9");

        // Clear in mid-list, then a fresh list must show no stale entries (R10)
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        y_mag = 8'd1; y_neg = 1'b1;
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1; in_cost = NB'(i); in_sym = SW'(i);
            @(negedge clk);
        end
        clr = 1'b1; in_valid = 1'b1; in_cost = 8'd3; in_sym = 3'd3;
        @(negedge clk);
        clr = 1'b0; in_valid = 1'b0;
        chk(out_valid == 1'b0, "R10", int'(out_valid), 0);
        c = '{4, 6, 6, 9, 13, 14, 20, 21};
        s = '{2, 4, 6, 1, 3, 5, 7, 0};
        run_list(c, s, 2, 1'b0, "R10");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule